// File: doc/BRIEF.md
# Early Receive Interrupt Generator

This block sits beside a receive DMA engine and watches the bytes of each frame as they are moved into host memory. Once the bytes moved for the current frame reach a programmed limit, it raises a one-cycle interrupt pulse and sets a sticky status bit, so the host can begin work before the frame has fully arrived. The limit comes from one of two sources. The first is a fine byte threshold in multiples of four bytes. The second is a coarse threshold in units of 64 bytes. A mode bit and a per-frame "protocol recognised" flag decide which source applies.

Software uses a small register port with three addresses. Select 0 is the fine threshold. Select 1 is the control register, holding the mode bit and the coarse field. Select 2 is status. The frame side gives a start-of-frame strobe with the recognised flag, transfer advances with their byte size, and an end-of-frame strobe. A three-state machine tracks each frame. IDLE means no frame is open. ARMED means a frame is open and its limit has not been reached. SPENT means the frame is open but has either fired or has no active limit.

The transitions are as follows:
- IDLE goes to ARMED on a start-of-frame with a non-zero limit that is not met at once.
- IDLE goes to SPENT on a start-of-frame whose limit is zero or is met at once.
- ARMED goes to SPENT when the count reaches the limit.
- Any state goes back to ARMED or SPENT on a new start-of-frame, by the same rule as above.
- Any state goes to IDLE on end-of-frame, which takes precedence.

Top module: `early_rx_irq`

## Requirements
- R1: After reset `irq_pulse` and `irq_status` are 0, and all three register selects read back 0.
- R2: Writing select 0 stores a fine threshold in bits 11:2. Readback of select 0 always shows bits 1:0 and 15:12 as zero.
- R3: Select 1 holds the mode bit at bit 0 and the 4-bit coarse field at bits 7:4. All other bits of select 1 read as zero. Select 3 reads as zero.
- R4: With the mode bit at 1, every frame uses the fine threshold as its limit.
- R5: With the mode bit at 0, a frame whose recognised flag is 0 at start-of-frame uses the fine threshold. A recognised frame uses the coarse field times 64 bytes.
- R6: A frame whose selected limit is zero raises no interrupt.
- R7: The running count includes the transfer in the current cycle, and a transfer on the start-of-frame cycle counts toward the new frame. `irq_pulse` is high in the cycle after the first cycle in which that count is greater than or equal to the limit, and it fires at most once per frame.
- R8: A frame that ends before reaching its limit raises no interrupt. Transfers while no frame is open are ignored.
- R9: The limit and its source are captured at start-of-frame. Register writes during a frame do not change that frame's limit.
- R10: A start-of-frame during an open frame restarts the count and re-arms the once-per-frame rule.
- R11: `irq_status` is set together with each pulse. It is cleared by writing 1 to bit 0 of select 2, and writing 0 there has no effect. When a set and a clear fall in the same cycle, the set wins. Select 2 bit 0 reads the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 2 | Write select (0 fine threshold, 1 control, 2 status) |
| cfg_wr_data | input | 16 | Write data |
| cfg_rd_sel | input | 2 | Read select |
| cfg_rd_data | output | 16 | Combinational readback of the selected register |
| rx_sof | input | 1 | Start of frame |
| rx_proto_known | input | 1 | Frame protocol recognised, sampled with `rx_sof` |
| rx_xfer_valid | input | 1 | A transfer to host memory happened this cycle |
| rx_xfer_bytes | input | 8 | Bytes moved by that transfer |
| rx_eof | input | 1 | End of frame |
| irq_pulse | output | 1 | One-cycle early receive interrupt |
| irq_status | output | 1 | Sticky interrupt status |

## Verification
Any error in the frame state shows at the ports: a pulse that is missing, late or repeated appears on `irq_pulse` within one cycle of the transfer that should have crossed the limit. A wrong captured limit or count shifts the pulse by at least one transfer. A corrupted register appears on `cfg_rd_data` within three cycles, because the bench rotates the read select continuously. A status bit that is stuck or cleared at the wrong time differs from the model on the very next edge.

// File: rtl/erx_pkg.sv
package erx_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ARMED = 2'd1,
        S_SPENT = 2'd2
    } erx_state_e;

    localparam logic [1:0] SEL_THR  = 2'd0;
    localparam logic [1:0] SEL_CTRL = 2'd1;
    localparam logic [1:0] SEL_STAT = 2'd2;
endpackage

// File: rtl/erx_cfg_regs.sv
module erx_cfg_regs
    import erx_pkg::*;
#(
    parameter int REG_W   = 16,
    parameter int THR_W   = 12,
    parameter int CRS_W   = 4,
    parameter int CRS_LSB = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    input  logic             status,
    output logic [REG_W-1:0] rd_data,
    output logic [THR_W-1:0] thr_byte,
    output logic             mode_all,
    output logic [CRS_W-1:0] crs_field,
    output logic             stat_clr
);
    logic [THR_W-1:2] thr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q     <= '0;
            mode_all  <= 1'b0;
            crs_field <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_THR)  thr_q <= wr_data[THR_W-1:2];
            if (wr_sel == SEL_CTRL) begin
                mode_all  <= wr_data[0];
                crs_field <= wr_data[CRS_LSB +: CRS_W];
            end
        end
    end

    assign thr_byte = {thr_q, 2'b00};
    assign stat_clr = wr_en && (wr_sel == SEL_STAT) && wr_data[0];

    always_comb begin
        rd_data = '0;
        unique case (rd_sel)
            SEL_THR:  rd_data[THR_W-1:0] = thr_byte;
            SEL_CTRL: begin
                rd_data[0]                  = mode_all;
                rd_data[CRS_LSB +: CRS_W]   = crs_field;
            end
            SEL_STAT: rd_data[0] = status;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/erx_thr_select.sv
module erx_thr_select #(
    parameter int THR_W     = 12,
    parameter int CRS_W     = 4,
    parameter int CRS_SHIFT = 6,
    parameter int ACT_W     = 12
) (
    input  logic [THR_W-1:0] thr_byte,
    input  logic [CRS_W-1:0] crs_field,
    input  logic             mode_all,
    input  logic             proto_known,
    output logic [ACT_W-1:0] active_thr
);
    logic [ACT_W-1:0] fine_ext;
    logic [ACT_W-1:0] coarse_ext;

    always_comb begin
        fine_ext   = ACT_W'(thr_byte);
        coarse_ext = ACT_W'(crs_field) << CRS_SHIFT;
        active_thr = (mode_all || !proto_known) ? fine_ext : coarse_ext;
    end
endmodule

// File: rtl/erx_frame_fsm.sv
module erx_frame_fsm
    import erx_pkg::*;
#(
    parameter int ACT_W  = 12,
    parameter int XFER_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof,
    input  logic              eof,
    input  logic              xfer_valid,
    input  logic [XFER_W-1:0] xfer_bytes,
    input  logic [ACT_W-1:0]  active_thr,
    output logic              fire,
    output logic              pulse,
    output erx_state_e        state
);
    localparam int CNT_W = ACT_W + 1;
    localparam int SUM_W = CNT_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    erx_state_e       nxt;
    logic [CNT_W-1:0] cnt_q;
    logic [ACT_W-1:0] lim_q;
    logic             live;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] total;
    logic [ACT_W-1:0] lim_use;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] add;
    erx_state_e       start_to;

    always_comb begin
        live    = sof || (state == S_ARMED);
        base    = sof ? '0 : cnt_q;
        lim_use = sof ? active_thr : lim_q;
        add     = xfer_valid ? SUM_W'(xfer_bytes) : '0;
        sum     = SUM_W'(base) + add;
        total   = (sum > SUM_W'(CNT_MAX)) ? CNT_MAX : sum[CNT_W-1:0];
        fire    = live && (lim_use != '0) && (total >= CNT_W'(lim_use));
    end

    always_comb begin
        start_to = (fire || active_thr == '0) ? S_SPENT : S_ARMED;
        nxt      = state;
        unique case (state)
            S_IDLE:  if (sof) nxt = start_to;
            S_ARMED: begin
                if (sof)       nxt = start_to;
                else if (fire) nxt = S_SPENT;
            end
            S_SPENT: if (sof) nxt = start_to;
            default: nxt = S_IDLE;
        endcase
        if (eof) nxt = S_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
            cnt_q <= '0;
            lim_q <= '0;
        end else begin
            pulse <= fire;
            if (live) cnt_q <= total;
            if (sof)  lim_q <= active_thr;
        end
    end
endmodule

// File: rtl/early_rx_irq.sv
module early_rx_irq
    import erx_pkg::*;
#(
    parameter int REG_W     = 16,
    parameter int THR_W     = 12,
    parameter int CRS_W     = 4,
    parameter int CRS_LSB   = 4,
    parameter int CRS_SHIFT = 6,
    parameter int XFER_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_wr_sel,
    input  logic [REG_W-1:0]  cfg_wr_data,
    input  logic [1:0]        cfg_rd_sel,
    output logic [REG_W-1:0]  cfg_rd_data,
    input  logic              rx_sof,
    input  logic              rx_proto_known,
    input  logic              rx_xfer_valid,
    input  logic [XFER_W-1:0] rx_xfer_bytes,
    input  logic              rx_eof,
    output logic              irq_pulse,
    output logic              irq_status
);
    localparam int CRS_SPAN = CRS_W + CRS_SHIFT;
    localparam int ACT_W    = (THR_W > CRS_SPAN) ? THR_W : CRS_SPAN;

    logic [THR_W-1:0] thr_byte;
    logic             mode_all;
    logic [CRS_W-1:0] crs_field;
    logic             stat_clr;
    logic [ACT_W-1:0] active_thr;
    logic             fire;
    erx_state_e       state;

    erx_cfg_regs #(
        .REG_W(REG_W), .THR_W(THR_W), .CRS_W(CRS_W), .CRS_LSB(CRS_LSB)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_sel(cfg_wr_sel),
        .wr_data(cfg_wr_data), .rd_sel(cfg_rd_sel), .status(irq_status),
        .rd_data(cfg_rd_data), .thr_byte(thr_byte), .mode_all(mode_all),
        .crs_field(crs_field), .stat_clr(stat_clr)
    );

    erx_thr_select #(
        .THR_W(THR_W), .CRS_W(CRS_W), .CRS_SHIFT(CRS_SHIFT), .ACT_W(ACT_W)
    ) u_sel (
        .thr_byte(thr_byte), .crs_field(crs_field), .mode_all(mode_all),
        .proto_known(rx_proto_known), .active_thr(active_thr)
    );

    erx_frame_fsm #(
        .ACT_W(ACT_W), .XFER_W(XFER_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .sof(rx_sof), .eof(rx_eof),
        .xfer_valid(rx_xfer_valid), .xfer_bytes(rx_xfer_bytes),
        .active_thr(active_thr), .fire(fire), .pulse(irq_pulse), .state(state)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)        irq_status <= 1'b0;
        else if (fire)     irq_status <= 1'b1;
        else if (stat_clr) irq_status <= 1'b0;
    end
endmodule

// File: rtl/erx_checker.sv
module erx_checker
    import erx_pkg::*;
#(
    parameter int REG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sof,
    input logic             irq_pulse,
    input logic             irq_status,
    input logic [1:0]       rd_sel,
    input logic [REG_W-1:0] rd_data,
    input erx_state_e       fsm_state
);
    // R11
    pulse_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> irq_status);

    // R11
    status_rise_needs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status) |-> irq_pulse);

    // R2
    thr_low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == SEL_THR) |-> (rd_data[1:0] == 2'b00 && rd_data[15:12] == 4'h0));

    // R3
    ctrl_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == SEL_CTRL) |-> (rd_data[3:1] == 3'b000 && rd_data[15:8] == 8'h00));

    // R8
    idle_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == S_IDLE && !sof) |=> !irq_pulse);

    // R7
    spent_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == S_SPENT && !sof) |=> !irq_pulse);
endmodule

bind early_rx_irq erx_checker #(.REG_W(REG_W)) u_erx_chk (
    .clk(clk), .rst_n(rst_n), .sof(rx_sof), .irq_pulse(irq_pulse),
    .irq_status(irq_status), .rd_sel(cfg_rd_sel), .rd_data(cfg_rd_data),
    .fsm_state(state)
);

// File: tb/test_early_rx_irq.sv
module test_early_rx_irq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_wr_sel = '0;
    logic [15:0] cfg_wr_data = '0;
    logic [1:0]  cfg_rd_sel = '0;
    logic [15:0] cfg_rd_data;
    logic        rx_sof = 1'b0;
    logic        rx_proto_known = 1'b0;
    logic        rx_xfer_valid = 1'b0;
    logic [7:0]  rx_xfer_bytes = '0;
    logic        rx_eof = 1'b0;
    logic        irq_pulse;
    logic        irq_status;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc_n = 0;
    string cur_req = "R1";

    early_rx_irq i_early_rx_irq (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data), .cfg_rd_sel(cfg_rd_sel), .cfg_rd_data(cfg_rd_data),
        .rx_sof(rx_sof), .rx_proto_known(rx_proto_known), .rx_xfer_valid(rx_xfer_valid),
        .rx_xfer_bytes(rx_xfer_bytes), .rx_eof(rx_eof), .irq_pulse(irq_pulse),
        .irq_status(irq_status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference
    int m_thr, m_mode, m_crs, m_stat, m_pulse, m_armed, m_cnt, m_lim;

    always @(posedge clk) begin
        int act, base, lim, tot, hit, live;
        if (!rst_n) begin
            m_thr = 0; m_mode = 0; m_crs = 0; m_stat = 0;
            m_pulse = 0; m_armed = 0; m_cnt = 0; m_lim = 0;
        end else begin
            act  = (m_mode != 0 || !rx_proto_known) ? m_thr : m_crs * 64;
            live = (rx_sof || m_armed != 0) ? 1 : 0;
            base = rx_sof ? 0 : m_cnt;
            lim  = rx_sof ? act : m_lim;
            tot  = base + (rx_xfer_valid ? int'(rx_xfer_bytes) : 0);
            if (tot > 8191) tot = 8191;
            hit  = (live != 0 && lim != 0 && tot >= lim) ? 1 : 0;
            m_pulse = hit;
            if (hit != 0) m_stat = 1;
            else if (cfg_wr_en && cfg_wr_sel == 2 && cfg_wr_data[0]) m_stat = 0;
            if (live != 0) m_cnt = tot;
            if (rx_sof) m_lim = act;
            if (rx_eof)          m_armed = 0;
            else if (hit != 0)   m_armed = 0;
            else if (rx_sof)     m_armed = (act != 0) ? 1 : 0;
            if (cfg_wr_en && cfg_wr_sel == 0) m_thr = int'(cfg_wr_data & 16'h0FFC);
            if (cfg_wr_en && cfg_wr_sel == 1) begin
                m_mode = int'(cfg_wr_data[0]);
                m_crs  = int'(cfg_wr_data[7:4]);
            end
        end
    end

    function automatic int exp_rd(input logic [1:0] sel);
        case (sel)
            2'd0:    return m_thr;
            2'd1:    return (m_crs << 4) | m_mode;
            2'd2:    return m_stat;
            default: return 0;
        endcase
    endfunction

    task automatic compare();
        n_vec++;
        if (irq_pulse !== m_pulse[0] || irq_status !== m_stat[0] ||
            int'(cfg_rd_data) != exp_rd(cfg_rd_sel)) begin
            n_bad++;
            $display("FAIL %s cyc %0d: pulse=%0b status=%0b rd[%0d]=%h, expected pulse=%0b status=%0b rd=%h",
                     cur_req, cyc_n, irq_pulse, irq_status, cfg_rd_sel, cfg_rd_data,
                     m_pulse[0], m_stat[0], exp_rd(cfg_rd_sel));
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        cyc_n++;
        compare();
        cfg_rd_sel    = (cfg_rd_sel == 2'd2) ? 2'd0 : cfg_rd_sel + 2'd1;
        cfg_wr_en     = 1'b0;
        rx_sof        = 1'b0;
        rx_eof        = 1'b0;
        rx_xfer_valid = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
        cyc();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    // frame of n transfers of b bytes; closes with eof when close is set
    task automatic frame(input logic known, input int n, input int b, input logic close);
        for (int i = 0; i < n; i++) begin
            rx_sof         = (i == 0);
            rx_proto_known = known;
            rx_xfer_valid  = 1'b1;
            rx_xfer_bytes  = 8'(b);
            rx_eof         = close && (i == n - 1);
            cyc();
        end
        idle(2);
    endtask

    initial begin
        int guard = 0;
        forever begin
            @(posedge clk);
            guard++;
            if (guard > 100000) begin
                n_bad++;
                $display("FAIL watchdog: actual=hung expected=finished");
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                $finish;
            end
        end
    end

    initial begin
        cur_req = "R1";
        idle(4);
        rst_n = 1'b1;
        idle(3);

        cur_req = "R2";
        wr(2'd0, 16'hFFFF); idle(3);
        wr(2'd0, 16'h0067); idle(3);
        cur_req = "R3";
        wr(2'd1, 16'hFFFF); idle(4);
        wr(2'd1, 16'h0030); idle(3);
        wr(2'd0, 16'd100);

        cur_req = "R5";
        frame(1'b0, 6, 32, 1'b1);
        frame(1'b1, 8, 32, 1'b1);
        cur_req = "R4";
        wr(2'd1, 16'h0031);
        frame(1'b1, 6, 32, 1'b1);
        frame(1'b0, 6, 25, 1'b1);

        cur_req = "R7";
        wr(2'd0, 16'd96);
        frame(1'b0, 5, 48, 1'b1);
        frame(1'b1, 2, 200, 1'b1);
        frame(1'b1, 1, 100, 1'b1);
        wr(2'd0, 16'd4092);
        frame(1'b0, 20, 255, 1'b1);

        cur_req = "R6";
        wr(2'd0, 16'd0);
        frame(1'b0, 6, 255, 1'b1);
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'd64);
        frame(1'b1, 6, 255, 1'b1);

        cur_req = "R8";
        frame(1'b0, 1, 32, 1'b1);
        rx_xfer_valid = 1'b1; rx_xfer_bytes = 8'd200; cyc();
        rx_xfer_valid = 1'b1; rx_xfer_bytes = 8'd200; cyc();
        idle(2);

        cur_req = "R9";
        rx_sof = 1'b1; rx_proto_known = 1'b0; rx_xfer_valid = 1'b1; rx_xfer_bytes = 8'd16; cyc();
        wr(2'd0, 16'd8);
        wr(2'd1, 16'h0001);
        rx_xfer_valid = 1'b1; rx_xfer_bytes = 8'd16; cyc();
        rx_xfer_valid = 1'b1; rx_xfer_bytes = 8'd40; cyc();
        rx_eof = 1'b1; cyc();
        idle(2);

        cur_req = "R10";
        wr(2'd0, 16'd100);
        frame(1'b0, 3, 30, 1'b0);
        frame(1'b0, 4, 30, 1'b0);
        frame(1'b0, 4, 30, 1'b1);

        cur_req = "R11";
        wr(2'd2, 16'h0000); idle(3);
        wr(2'd2, 16'h0001); idle(3);
        rx_sof = 1'b1; rx_xfer_valid = 1'b1; rx_xfer_bytes = 8'd120;
        cfg_wr_en = 1'b1; cfg_wr_sel = 2'd2; cfg_wr_data = 16'h0001;
        cyc();
        idle(3);
        wr(2'd2, 16'hFFFF); idle(3);

        cur_req = "R1";
        rst_n = 1'b0; idle(3);
        rst_n = 1'b1; idle(3);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule